// File: doc/BRIEF.md
# Two-Wire Slave Register Port

This block is a slave on a two-wire serial bus (I2C/SMBus compatible). It samples the clock and data lines through synchronisers running on a faster system clock, recognises start and stop conditions, and compares the first byte of every transaction against a 7-bit device address. When the address matches, the block acknowledges it and opens a byte-wide internal port to a register file that sits outside the block.

A write transaction always carries a pointer byte first. The pointer is held until a later write replaces it, so software can set the pointer once and then read the same location many times. Data bytes after the pointer become write strobes on the internal port. A read transaction streams bytes from the pointer onward without moving the stored pointer. Two pointer values are treated as commands rather than storage: one gives a software-reset pulse and the other a one-shot pulse.

The block also acknowledges the general-call address and turns command byte 06h into a reset pulse. It flags, without acknowledging, the high-speed master code, and keeps that flag up until the next stop. It releases the bus and goes back to idle when a line stays low with no clock activity for a parameterised number of system clocks. SDA is modelled as an output enable that pulls the line low.

Top module: `twi_reg_slave`

## Requirements
- R1: A falling SDA while SCL is high is a start condition and a rising SDA while SCL is high is a stop condition. Clock pulses that arrive without a preceding start are ignored and are never acknowledged.
- R2: The first byte after a start is an address byte. If its bits 7..1 equal DEV_ADDR, the slave pulls SDA low in the ninth clock (ACK). Any other non-special address gets no ACK, and later bytes get no ACK and no strobe until the next start or stop.
- R3: In a write (address bit 0 = 0), the first byte after the address is acknowledged and loaded into an 8-bit pointer. The pointer keeps its value through later reads until another write changes it. Reset sets it to 00h.
- R4: Every later byte of a write is acknowledged and gives a one-cycle reg_wr_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte.
- R5: In a read (address bit 0 = 1), the slave sends reg_rdata_i for reg_addr_o = pointer, then pointer+1 and so on, most significant bit first, with one reg_rd_o pulse per byte. A master ACK asks for the next byte and a master NACK ends the read with SDA released. The stored pointer is not changed.
- R6: A first byte of the form 0000_1xxx is not acknowledged and sets hs_mode_o. The flag survives repeated starts and clears on the next stop or timeout.
- R7: The general-call address 00h and the byte after it are both acknowledged. A second byte of 06h gives a soft_rst_o pulse and clears the pointer to 00h. Any other second byte has no effect.
- R8: While a transaction is open, if SCL or SDA stays low with no SCL edge for TIMEOUT_CYC system clocks, the slave releases SDA, drops hs_mode_o and ignores the bus until the next start. The pointer is kept.
- R9: A data byte written at pointer FCh gives a soft_rst_o pulse and clears the pointer. A data byte written at pointer 0Fh gives a oneshot_o pulse. In both cases the byte is discarded and reg_wr_o stays low.
- R10: After reset, sda_oe_o = 0, hs_mode_o = 0, reg_addr_o = 00h, and no strobe or pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| hs_mode_o | output | 1 | High-speed master code seen since the last stop |
| reg_addr_o | output | 8 | Register address: pointer plus read byte offset |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_rd_o | output | 1 | One-cycle pulse when a read byte is taken |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |
| soft_rst_o | output | 1 | One-cycle software reset pulse |
| oneshot_o | output | 1 | One-cycle one-shot start pulse |

## Verification
The data byte written at pointer FCh has two effects at the same ack-slot edge: the write strobe path has to be held off, and the software reset has to fire and clear the pointer. Writing FCh followed by a data byte provokes this. The bench then confirms that reg_wr_o never pulsed, that soft_rst_o pulsed exactly once, and that a later read without a new pointer returns the register at address 00h. The general-call 06h reset is checked against the same pointer-clearing effect.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE, MODE_ADDR, MODE_WR, MODE_RD, MODE_GC, MODE_IGN
  } twi_mode_e;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;
  localparam logic [7:0] PTR_SOFT_RST = 8'hFC;
  localparam logic [7:0] PTR_ONESHOT  = 8'h0F;
  localparam logic [4:0] HS_CODE_TOP  = 5'b00001;
endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_sr, sda_sr;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[STAGES-1:0], sda_i};
    end
  end

  assign scl_o    = scl_sr[STAGES-1];
  assign sda_o    = sda_sr[STAGES-1];
  assign scl_prev = scl_sr[STAGES];
  assign sda_prev = sda_sr[STAGES];

  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/twi_timeout.sv
`timescale 1ns/1ps
module twi_timeout #(
  parameter int TIMEOUT_CYC = 1500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic scl_i,
  input  logic sda_i,
  input  logic scl_edge_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic run, hit;

  // a low line counts only while no SCL edge shows progress
  assign run = busy_i & ~(scl_i & sda_i) & ~scl_edge_i;
  assign hit = run & (cnt_q == LAST);
  assign expire_o = hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run || hit) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assert_timeout_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TIMEOUT_CYC));
  assert_idle_no_expire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !expire_o);
endmodule

// File: rtl/twi_byte_engine.sv
`timescale 1ns/1ps
module twi_byte_engine
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       expire_i,
  output logic       busy_o,
  output logic       sda_oe_o,
  output logic       hs_o,
  output logic [7:0] reg_addr_o,
  output logic       reg_wr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_rd_o,
  input  logic [7:0] reg_rdata_i,
  output logic       soft_rst_o,
  output logic       oneshot_o
);
  twi_mode_e   mode_q;
  logic        busy_q, in_ack_q, oe_q, hs_q, ptr_done_q, rd_first_q, mack_q;
  logic [3:0]  cnt_q;
  logic [7:0]  rx_q, ptr_q, rd_idx_q, wdata_q;
  logic [6:0]  tx_q;
  logic        wr_q, soft_q, one_q;
  logic        ack_enter, ack_exit, rd_ld, ptr_ld;

  assign ack_enter = scl_fall_i & busy_q & ~in_ack_q & (cnt_q == 4'd8);
  assign ack_exit  = scl_fall_i & busy_q & in_ack_q;
  assign rd_ld     = ack_exit & (mode_q == MODE_RD) & (rd_first_q | mack_q)
                   & ~stop_i & ~start_i & ~expire_i;
  assign ptr_ld    = ack_enter & (mode_q == MODE_WR) & ~ptr_done_q
                   & ~stop_i & ~start_i & ~expire_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE; busy_q <= 1'b0; in_ack_q <= 1'b0; oe_q <= 1'b0;
      hs_q <= 1'b0; ptr_done_q <= 1'b0; rd_first_q <= 1'b0; mack_q <= 1'b0;
      cnt_q <= '0; rx_q <= '0; ptr_q <= '0; rd_idx_q <= '0; wdata_q <= '0;
      tx_q <= '1; wr_q <= 1'b0; soft_q <= 1'b0; one_q <= 1'b0;
    end else begin
      wr_q <= 1'b0; soft_q <= 1'b0; one_q <= 1'b0;
      if (stop_i || expire_i) begin
        mode_q <= MODE_IDLE; busy_q <= 1'b0; in_ack_q <= 1'b0;
        oe_q <= 1'b0; hs_q <= 1'b0; rd_idx_q <= '0;
      end else if (start_i) begin
        mode_q <= MODE_ADDR; busy_q <= 1'b1; in_ack_q <= 1'b0; oe_q <= 1'b0;
        cnt_q <= '0; ptr_done_q <= 1'b0; rd_first_q <= 1'b0; rd_idx_q <= '0;
      end else if (busy_q) begin
        if (scl_rise_i) begin
          if (in_ack_q) mack_q <= ~sda_i;
          else if (cnt_q < 4'd8) begin
            rx_q  <= {rx_q[6:0], sda_i};
            cnt_q <= cnt_q + 4'd1;
          end
        end else if (ack_enter) begin
          in_ack_q <= 1'b1;
          cnt_q    <= '0;
          case (mode_q)
            MODE_ADDR: begin
              if (rx_q[7:1] == DEV_ADDR) begin
                oe_q <= 1'b1; rd_first_q <= rx_q[0];
                mode_q <= rx_q[0] ? MODE_RD : MODE_WR;
              end else if (rx_q == GC_ADDR_BYTE) begin
                oe_q <= 1'b1; mode_q <= MODE_GC;
              end else begin
                if (rx_q[7:3] == HS_CODE_TOP) hs_q <= 1'b1;
                mode_q <= MODE_IGN;
              end
            end
            MODE_WR: begin
              oe_q <= 1'b1;
              if (!ptr_done_q) begin
                ptr_q <= rx_q; ptr_done_q <= 1'b1;
              end else if (ptr_q == PTR_SOFT_RST) begin
                soft_q <= 1'b1; ptr_q <= '0;
              end else if (ptr_q == PTR_ONESHOT) begin
                one_q <= 1'b1;
              end else begin
                wr_q <= 1'b1; wdata_q <= rx_q;
              end
            end
            MODE_GC: begin
              oe_q <= 1'b1; mode_q <= MODE_IGN;
              if (rx_q == GC_RESET_CMD) begin
                soft_q <= 1'b1; ptr_q <= '0;
              end
            end
            default: oe_q <= 1'b0;  // read: master owns the ack slot
          endcase
        end else if (ack_exit) begin
          in_ack_q <= 1'b0;
          if (rd_ld) begin
            tx_q <= reg_rdata_i[6:0]; oe_q <= ~reg_rdata_i[7];
            rd_idx_q <= rd_idx_q + 8'd1; rd_first_q <= 1'b0;
          end else begin
            oe_q <= 1'b0;
            if (mode_q == MODE_RD) mode_q <= MODE_IGN;
          end
        end else if (scl_fall_i && mode_q == MODE_RD && cnt_q != 4'd0) begin
          oe_q <= ~tx_q[6];
          tx_q <= {tx_q[5:0], 1'b1};
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign sda_oe_o    = oe_q;
  assign hs_o        = hs_q;
  assign reg_addr_o  = ptr_q + rd_idx_q;
  assign reg_wr_o    = wr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_rd_o    = rd_ld;
  assign soft_rst_o  = soft_q;
  assign oneshot_o   = one_q;

  assert_release_on_timeout_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> !sda_oe_o);
  assert_hs_never_acked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_o) |-> !sda_oe_o);
  assert_hs_clear_on_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !hs_o);
  assert_drive_only_open_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> busy_q);
  assert_cmd_ptr_no_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (reg_addr_o != PTR_SOFT_RST && reg_addr_o != PTR_ONESHOT));
  assert_ptr_moves_only_on_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ptr_q) |-> (soft_rst_o || $past(ptr_ld)));
endmodule

// File: rtl/twi_reg_slave.sv
`timescale 1ns/1ps
module twi_reg_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         TIMEOUT_CYC = 1500000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       hs_mode_o,
  output logic [7:0] reg_addr_o,
  output logic       reg_wr_o,
  output logic [7:0] reg_wdata_o,
  output logic       reg_rd_o,
  input  logic [7:0] reg_rdata_i,
  output logic       soft_rst_o,
  output logic       oneshot_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c, expire, busy;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  twi_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk_i, .rst_ni, .busy_i(busy), .scl_i(scl_s), .sda_i(sda_s),
    .scl_edge_i(scl_rise | scl_fall), .expire_o(expire)
  );

  twi_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_eng (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_c), .stop_i(stop_c), .expire_i(expire), .busy_o(busy),
    .sda_oe_o, .hs_o(hs_mode_o), .reg_addr_o, .reg_wr_o, .reg_wdata_o,
    .reg_rd_o, .reg_rdata_i, .soft_rst_o, .oneshot_o
  );
endmodule

// File: tb/twi_reg_slave_bench.sv
`timescale 1ns/1ps
module twi_reg_slave_bench;
  localparam logic [6:0] ADDR = 7'h4C;
  localparam int TMO = 300;
  localparam int Q   = 8;
  localparam logic [7:0] K_W = 8'd0, K_P = 8'd1, K_R1 = 8'd2, K_R2 = 8'd3;
  localparam int NVEC = 10;
  // {kind, pointer, data, expect0, expect1}; regs start at addr ^ 3Ch
  localparam logic [39:0] VEC [NVEC] = '{
    {K_W,  8'h10, 8'hA7, 8'h00, 8'h00},
    {K_R1, 8'h00, 8'h00, 8'hA7, 8'h00},
    {K_R1, 8'h00, 8'h00, 8'hA7, 8'h00},
    {K_P,  8'h20, 8'h00, 8'h00, 8'h00},
    {K_R2, 8'h00, 8'h00, 8'h1C, 8'h1D},
    {K_W,  8'h21, 8'h00, 8'h00, 8'h00},
    {K_R2, 8'h00, 8'h00, 8'h00, 8'h1E},
    {K_W,  8'h80, 8'hFF, 8'h00, 8'h00},
    {K_R1, 8'h00, 8'h00, 8'hFF, 8'h00},
    {K_R2, 8'h00, 8'h00, 8'hFF, 8'hBD}
  };

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, hs, reg_wr, reg_rd, soft_rst, oneshot;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] regs [256];
  wire sda_line = sda_m & ~sda_oe;
  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0, soft_cnt = 0, one_cnt = 0;
  logic [7:0] last_wa = 0, last_wd = 0;

  always #5 clk = ~clk;

  twi_reg_slave #(.DEV_ADDR(ADDR), .TIMEOUT_CYC(TMO)) u_twi_reg_slave (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .hs_mode_o(hs), .reg_addr_o(reg_addr), .reg_wr_o(reg_wr),
    .reg_wdata_o(reg_wdata), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata),
    .soft_rst_o(soft_rst), .oneshot_o(oneshot)
  );

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'(i) ^ 8'h3C;
    end else begin
      if (reg_wr) begin
        regs[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1;
        last_wa <= reg_addr; last_wd <= reg_wdata;
      end
      if (reg_rd)   rd_cnt   <= rd_cnt + 1;
      if (soft_rst) soft_cnt <= soft_cnt + 1;
      if (oneshot)  one_cnt  <= one_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1; wq(2); scl_m = 0; wq();
    end
    sda_m = 1; wq(); scl_m = 1; wq(); acked = !sda_line; wq(); scl_m = 0; wq();
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1; wq(); b[i] = sda_line; wq(); scl_m = 0;
    end
    wq(); sda_m = !give_ack; wq(); scl_m = 1; wq(2); scl_m = 0; wq(); sda_m = 1;
  endtask

  task automatic xfer_write(input logic [7:0] p, input logic [7:0] d, input bit has_data);
    bit a;
    bus_start();
    send_byte({ADDR, 1'b0}, a); chk(a, "R2 address ack", 16'(a), 16'd1);
    send_byte(p, a);            chk(a, "R3 pointer ack", 16'(a), 16'd1);
    if (has_data) begin
      send_byte(d, a);          chk(a, "R4 data ack", 16'(a), 16'd1);
    end
    bus_stop();
  endtask

  task automatic xfer_read(input bit two, output logic [7:0] b0, output logic [7:0] b1);
    bit a;
    b1 = '0;
    bus_start();
    send_byte({ADDR, 1'b1}, a); chk(a, "R2 read address ack", 16'(a), 16'd1);
    read_byte(two, b0);
    if (two) read_byte(1'b0, b1);
    bus_stop();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired act=%h exp=%h", 16'd1, 16'd0);
    summary();
  end

  initial begin
    logic [7:0] b0, b1;
    bit a;
    int w0, s0, o0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R10: reset state
    chk(sda_oe == 0 && hs == 0, "R10 outputs idle", {14'd0, sda_oe, hs}, 16'd0);
    chk(reg_addr == 8'h00, "R10 pointer 00h", 16'(reg_addr), 16'h0);
    chk(wr_cnt + soft_cnt + one_cnt == 0 && !reg_wr, "R10 no pulses", 16'(wr_cnt + soft_cnt + one_cnt), 16'd0);

    // R3: read before any write uses the reset pointer
    xfer_read(1'b0, b0, b1);
    chk(b0 == 8'h3C, "R3 reset pointer read", 16'(b0), 16'h3C);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] k, p, d, e0, e1;
      {k, p, d, e0, e1} = VEC[v];
      w0 = wr_cnt; r0 = rd_cnt;
      case (k)
        K_W: begin
          xfer_write(p, d, 1'b1);
          chk(wr_cnt == w0 + 1, "R4 one write strobe", 16'(wr_cnt - w0), 16'd1);
          chk(last_wa == p && last_wd == d, "R4 write addr/data", {last_wa, last_wd}, {p, d});
        end
        K_P: begin
          xfer_write(p, 8'h00, 1'b0);
          chk(wr_cnt == w0, "R3 pointer-only no strobe", 16'(wr_cnt - w0), 16'd0);
        end
        K_R1: begin
          xfer_read(1'b0, b0, b1);
          chk(b0 == e0, "R5 single read (R3 pointer kept)", 16'(b0), 16'(e0));
          chk(rd_cnt == r0 + 1, "R5 one read pulse", 16'(rd_cnt - r0), 16'd1);
        end
        default: begin
          xfer_read(1'b1, b0, b1);
          chk({b0, b1} == {e0, e1}, "R5 two-byte read", {b0, b1}, {e0, e1});
          chk(rd_cnt == r0 + 2, "R5 two read pulses", 16'(rd_cnt - r0), 16'd2);
        end
      endcase
    end

    // R2: address mismatch, rest ignored
    w0 = wr_cnt;
    bus_start();
    send_byte({7'h2A, 1'b0}, a); chk(!a, "R2 mismatch no ack", 16'(a), 16'd0);
    send_byte(8'h11, a);         chk(!a, "R2 ignored byte no ack", 16'(a), 16'd0);
    send_byte(8'h22, a);
    bus_stop();
    chk(wr_cnt == w0, "R2 no strobe after mismatch", 16'(wr_cnt - w0), 16'd0);

    // R1: clocking without a start is ignored
    send_byte({ADDR, 1'b0}, a);
    chk(!a, "R1 no ack without start", 16'(a), 16'd0);
    bus_stop();

    // R6: high-speed master code
    bus_start();
    send_byte(8'h0A, a);
    chk(!a, "R6 hs code not acked", 16'(a), 16'd0);
    chk(hs == 1, "R6 hs flag set", 16'(hs), 16'd1);
    bus_start();
    chk(hs == 1, "R6 hs kept over repeated start", 16'(hs), 16'd1);
    send_byte({ADDR, 1'b0}, a); chk(a, "R6 address after hs acked", 16'(a), 16'd1);
    send_byte(8'h30, a);
    bus_stop();
    chk(hs == 0, "R6 hs cleared by stop", 16'(hs), 16'd0);

    // R7: general call with a non-reset byte
    s0 = soft_cnt;
    bus_start();
    send_byte(8'h00, a); chk(a, "R7 general call acked", 16'(a), 16'd1);
    send_byte(8'h04, a); chk(a, "R7 second byte acked", 16'(a), 16'd1);
    bus_stop();
    chk(soft_cnt == s0, "R7 other byte no reset", 16'(soft_cnt - s0), 16'd0);
    xfer_write(8'h44, 8'h00, 1'b0);
    bus_start();
    send_byte(8'h00, a); send_byte(8'h06, a);
    bus_stop();
    chk(soft_cnt == s0 + 1, "R7 reset pulse", 16'(soft_cnt - s0), 16'd1);
    xfer_read(1'b0, b0, b1);
    chk(b0 == 8'h3C, "R7 pointer cleared", 16'(b0), 16'h3C);

    // R9: command pointers discard data; FCh write also clears pointer
    w0 = wr_cnt; o0 = one_cnt; s0 = soft_cnt;
    xfer_write(8'h0F, 8'h99, 1'b1);
    chk(one_cnt == o0 + 1, "R9 one-shot pulse", 16'(one_cnt - o0), 16'd1);
    xfer_read(1'b0, b0, b1);
    chk(b0 == 8'h33, "R9 0Fh data discarded", 16'(b0), 16'h33);
    xfer_write(8'hFC, 8'h12, 1'b1);
    chk(soft_cnt == s0 + 1, "R9 soft reset pulse", 16'(soft_cnt - s0), 16'd1);
    chk(wr_cnt == w0, "R9 no write strobe", 16'(wr_cnt - w0), 16'd0);
    xfer_read(1'b0, b0, b1);
    chk(b0 == 8'h3C, "R9 pointer cleared by FCh", 16'(b0), 16'h3C);

    // R8: bus stalled while slave drives a 0 bit (regs[05h] = 39h)
    xfer_write(8'h05, 8'h00, 1'b0);
    bus_start();
    send_byte({ADDR, 1'b1}, a);
    repeat (10) @(negedge clk);
    chk(sda_oe == 1, "R8 slave driving before timeout", 16'(sda_oe), 16'd1);
    repeat (200) @(negedge clk);
    chk(sda_oe == 1, "R8 still driving inside window", 16'(sda_oe), 16'd1);
    repeat (120) @(negedge clk);
    chk(sda_oe == 0, "R8 released after timeout", 16'(sda_oe), 16'd0);
    send_byte({ADDR, 1'b0}, a);
    chk(!a, "R8 idle until new start", 16'(a), 16'd0);
    bus_stop();
    xfer_read(1'b0, b0, b1);
    chk(b0 == 8'h39, "R8 pointer kept over timeout", 16'(b0), 16'h39);

    summary();
  end
endmodule